// File: doc/BRIEF.md
# Prescaled 8-bit timer with compare-match clear

This block counts prescaled clock ticks in an 8-bit register. A 3-bit clock-select code either stops the count or divides the system clock by 1, 8, 32, 64, 128, 256 or 1024. The counter has two modes:

- **Free-running mode:** the counter wraps past its top value and raises an overflow flag.
- **Clear-on-match mode:** the counter restarts from zero on the tick after it equals a programmable compare value. Compare events then recur at the prescaled rate divided by the compare value plus one.

Each of the two flags has its own enable bit. The interrupt request is active while any enabled flag is set.

Software sets the mode, clock select, compare value and enables over a small register bus with one write strobe, a shared address and a combinational read port. A flag is cleared in one of two ways: by writing a one to its bit, or by a per-flag acknowledge pulse from the interrupt controller. Register map, by address:

| Address | Register | Content |
|---|---|---|
| 0 | Control | bits 2:0 clock select, bit 3 clear-on-match mode |
| 1 | Compare | compare value |
| 2 | Enable | bit 0 compare enable, bit 1 overflow enable |
| 3 | Flags | bit 0 compare flag, bit 1 overflow flag |
| 4 | Count | read only |

Top module: `tmr8_ctc`

## Requirements
- R1: After reset, every register (control, compare, enable, flags and count) reads zero and `irq` is low.
- R2: Clock-select codes 001 to 111 give ticks every 1, 8, 32, 64, 128, 256 and 1024 clock cycles. A write to the control register restarts the prescaler, so the first tick falls N cycles after the write edge.
- R3: With clock select 000, the count keeps its value.
- R4: In free-running mode, a tick at count 255 moves the count to 0 and sets the overflow flag (flags bit 1).
- R5: In clear-on-match mode, a tick at a count equal to the compare value moves the count to 0 and sets the compare flag (flags bit 0). From count 0, the first compare event therefore comes (compare+1)·N cycles after the control write.
- R6: In free-running mode, a tick at a count equal to the compare value sets the compare flag, and counting continues upward.
- R7: Writing the flags register clears each flag whose data bit is 1. Bits written as 0 leave their flag unchanged.
- R8: A one-cycle pulse on `irq_ack[i]` clears flag i.
- R9: When a tick sets a flag in the same cycle that a write or acknowledge clears it, the flag ends set.
- R10: `irq` is high exactly when (compare flag AND enable bit 0) OR (overflow flag AND enable bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_ack | input | 2 | Per-flag acknowledge, bit 0 compare, bit 1 overflow |
| irq | output | 1 | Interrupt request |

## Verification
A prescaled tick can set a flag in the same cycle that software clears it, either by a write of one or by an acknowledge pulse.

The bench provokes this collision in clear-on-match mode with divide-by-1 and compare value 3. It places the clearing write exactly (compare+1) cycles after the control write, and the acknowledge exactly one compare period later. It judges the result by reading the flags register afterwards: the flag must stay set. A clear issued one cycle away from a match must take effect.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL  = 3'd0,
        ADR_CMP   = 3'd1,
        ADR_EN    = 3'd2,
        ADR_FLAGS = 3'd3,
        ADR_COUNT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       ctc;
        logic [2:0] csel;
    } ctrl_t;

    // log2 of the prescale ratio for each clock-select code
    function automatic logic [3:0] div_log2(input logic [2:0] csel);
        case (csel)
            3'd1:    div_log2 = 4'd0;
            3'd2:    div_log2 = 4'd3;
            3'd3:    div_log2 = 4'd5;
            3'd4:    div_log2 = 4'd6;
            3'd5:    div_log2 = 4'd7;
            3'd6:    div_log2 = 4'd8;
            default: div_log2 = 4'd10;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [2:0] csel,
    output logic       tick
);
    import tmr8_pkg::*;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        st_d     = st_q;
        low_mask = PRE_W'((1 << div_log2(csel)) - 1);
        tick     = (csel != 3'd0) && ((st_q.pre & low_mask) == low_mask);
        if (restart) st_d.pre = '0;
        else         st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctc,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             cmp_hit,
    output logic             ovf_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cmp_hit = tick && (st_q.cnt == cmp);
        ovf_hit = 1'b0;
        if (tick) begin
            if (ctc && cmp_hit) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                ovf_hit  = (st_q.cnt == {CNT_W{1'b1}});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] ack,
    input  logic [NFLAG-1:0] enable,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] f;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            // a set in the same cycle overrides any clear
            st_d.f[i] = set[i] | (st_q.f[i] & ~clr[i] & ~ack[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags = st_q.f;
    assign irq   = |(st_q.f & enable);
endmodule

// File: rtl/tmr8_ctc.sv
module tmr8_ctc #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [1:0]       irq_ack,
    output logic             irq
);
    import tmr8_pkg::*;

    localparam int NFLAG = 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
        logic [NFLAG-1:0] en;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             wr_ctrl;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             cmp_hit, ovf_hit;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] flag_clr;

    always_comb begin
        rg_d     = rg_q;
        wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
        flag_clr = '0;
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                ADR_CTRL:  rg_d.ctrl = ctrl_t'(bus_wdata[3:0]);
                ADR_CMP:   rg_d.cmp  = bus_wdata;
                ADR_EN:    rg_d.en   = bus_wdata[NFLAG-1:0];
                ADR_FLAGS: flag_clr  = bus_wdata[NFLAG-1:0];
                default:   ;
            endcase
        end
        case (reg_addr_e'(bus_addr))
            ADR_CTRL:  bus_rdata = CNT_W'(rg_q.ctrl);
            ADR_CMP:   bus_rdata = rg_q.cmp;
            ADR_EN:    bus_rdata = CNT_W'(rg_q.en);
            ADR_FLAGS: bus_rdata = CNT_W'(flags);
            ADR_COUNT: bus_rdata = count;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rg_q <= '0;
        else     rg_q <= rg_d;
    end

    tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_ctrl),
        .csel    (rg_q.ctrl.csel),
        .tick    (tick)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ctc     (rg_q.ctrl.ctc),
        .cmp     (rg_q.cmp),
        .count   (count),
        .cmp_hit (cmp_hit),
        .ovf_hit (ovf_hit)
    );

    tmr8_flags #(.NFLAG(NFLAG)) u_flg (
        .clk    (clk),
        .rst    (rst),
        .set    ({ovf_hit, cmp_hit}),
        .clr    (flag_clr),
        .ack    (irq_ack),
        .enable (rg_q.en),
        .flags  (flags),
        .irq    (irq)
    );
endmodule

// File: rtl/tmr8_ctc_chk.sv
module tmr8_ctc_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [3:0]       ctrl,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       flags,
    input logic [1:0]       flag_clr,
    input logic [1:0]       irq_ack
);
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl[2:0] == 3'd0) |=> $stable(count));

    a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl[3] && count == {CNT_W{1'b1}}) |=> (count == '0 && flags[1]));

    a_r5_ctc_clears: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl[3] && count == cmp) |=> (count == '0 && flags[0]));

    a_r6_free_run_steps: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl[3] && count != {CNT_W{1'b1}}) |=> (count == $past(count) + 1'b1));

    a_r9_cmp_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !flag_clr[0] && !irq_ack[0]) |=> flags[0]);

    a_r8_ack_clears_ovf: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[1] && !(tick && count == {CNT_W{1'b1}})) |=> !flags[1]);
endmodule

bind tmr8_ctc tmr8_ctc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ctrl     (rg_q.ctrl),
    .cmp      (rg_q.cmp),
    .count    (count),
    .flags    (flags),
    .flag_clr (flag_clr),
    .irq_ack  (irq_ack)
);

// File: tb/tmr8_ctc_tb.sv
module tmr8_ctc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {clock select, compare value, prescale ratio}
    localparam logic [42:0] VEC [NVEC] = '{
        {3'd1, 8'd5,  32'd1},
        {3'd2, 8'd3,  32'd8},
        {3'd3, 8'd10, 32'd32},
        {3'd4, 8'd2,  32'd64},
        {3'd5, 8'd1,  32'd128},
        {3'd6, 8'd0,  32'd256},
        {3'd7, 8'd2,  32'd1024}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] irq_ack = 2'b00;
    logic       irq;
    int checks = 0;
    int bad = 0;
    bit done = 0;

    tmr8_ctc u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int cs, cm, dv;
        do_reset();

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 0);
        end
        check("R1 irq", int'(irq), 0);

        // R2/R5 table: CTC period per clock-select code
        for (int i = 0; i < NVEC; i++) begin
            cs = int'(VEC[i][42:40]);
            cm = int'(VEC[i][39:32]);
            dv = int'(VEC[i][31:0]);
            do_reset();
            wr(3'd1, 8'(cm));
            wr(3'd2, 8'd1);
            wr(3'd0, 8'(8 | cs));
            repeat ((cm + 1) * dv - 1) @(negedge clk);
            rd(3'd3, v);
            check("R2 flag before period", v & 1, 0);
            check("R10 irq before period", int'(irq), 0);
            @(negedge clk);
            rd(3'd3, v);
            check("R5 flag at period", v & 1, 1);
            rd(3'd4, v);
            check("R5 count cleared", v, 0);
            check("R10 irq at period", int'(irq), 1);
        end

        // R4 free-running wrap, divide-by-1
        do_reset();
        wr(3'd1, 8'd200);
        wr(3'd0, 8'd1);
        repeat (255) @(negedge clk);
        rd(3'd4, v);
        check("R4 count at top", v, 255);
        rd(3'd3, v);
        check("R4 ovf before wrap", (v >> 1) & 1, 0);
        @(negedge clk);
        rd(3'd4, v);
        check("R4 count wrapped", v, 0);
        rd(3'd3, v);
        check("R4 ovf set", (v >> 1) & 1, 1);
        check("R10 irq masked", int'(irq), 0);
        wr(3'd2, 8'd2);
        check("R10 irq enabled", int'(irq), 1);
        wr(3'd3, 8'd0);
        rd(3'd3, v);
        check("R7 zero write keeps", (v >> 1) & 1, 1);
        wr(3'd3, 8'd2);
        rd(3'd3, v);
        check("R7 one write clears", (v >> 1) & 1, 0);
        check("R10 irq after clear", int'(irq), 0);

        // R3 stopped
        wr(3'd0, 8'd0);
        rd(3'd4, cm);
        repeat (20) @(negedge clk);
        rd(3'd4, v);
        check("R3 count held", v, cm);

        // R6 compare in free-running mode, then R8 acknowledge
        do_reset();
        wr(3'd1, 8'd10);
        wr(3'd0, 8'd1);
        repeat (10) @(negedge clk);
        rd(3'd3, v);
        check("R6 flag before match", v & 1, 0);
        @(negedge clk);
        rd(3'd3, v);
        check("R6 flag on match", v & 1, 1);
        rd(3'd4, v);
        check("R6 count continues", v, 11);
        irq_ack = 2'b01;
        @(negedge clk);
        irq_ack = 2'b00;
        rd(3'd3, v);
        check("R8 ack clears", v & 1, 0);

        // R9 set beats clear in the same cycle
        do_reset();
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd9);
        repeat (3) @(negedge clk);
        wr(3'd3, 8'd1);
        rd(3'd3, v);
        check("R9 write collision", v & 1, 1);
        wr(3'd3, 8'd1);
        rd(3'd3, v);
        check("R7 clear off match", v & 1, 0);
        @(negedge clk);
        @(negedge clk);
        irq_ack = 2'b01;
        @(negedge clk);
        irq_ack = 2'b00;
        rd(3'd3, v);
        check("R9 ack collision", v & 1, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule